// File: doc/BRIEF.md
# Divider-Driven Programmable Timer

This block is a system timer that runs from one master clock. A 2-bit prescaler advances on every master clock, and its wrap advances a 14-bit divider. Together they form a 16-bit free-running count. The control register picks one bit of that count and gates it with an enable bit. A falling-edge detector on the gated bit advances an 8-bit timer counter. When the counter wraps, it holds zero for one machine cycle (four master clocks). It then reloads from a modulo register and pulses an interrupt request.

The enable gate sits in front of the edge detector, and a divider write clears only the 14-bit part of the count. Because of this, register writes can themselves advance the counter. The block also produces a clock-enable strobe for an audio frame sequencer, taken from a falling edge of a divider bit. Every strobe in the block is a clock enable on the master clock.

A simple byte-wide port gives access to the registers. A write takes effect at the clock edge where `cpu_wr` is high. Read data is registered: it shows the register that `cpu_addr` selected at the previous edge.

Top module: `divtim_top`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, and `timer_irq` and `frame_ce` are low.
- R2: The 16-bit count (divider in bits 15:2, prescaler in bits 1:0) goes up by one on every master clock. Address 0 reads count bits 15:8. `cpu_rdata` shows, one clock later, the register selected at that edge.
- R3: Control bits [1:0] choose the count bit that clocks the counter: 0 picks bit 9, 1 picks bit 3, 2 picks bit 5 and 3 picks bit 7. The counter (address 1) goes up by one, one clock after each falling edge of the selected bit.
- R4: Control bit 2 is ANDed with the selected bit before edge detection. Clearing it while the selected bit is high advances the counter by one.
- R5: When the counter wraps from 0xFF, it reads 0x00 for four master clocks. On the next clock it loads the modulo value (address 2), and `timer_irq` is high for exactly one clock.
- R6: Any write to address 0 clears count bits 15:2. If this drops the gated bit from 1 to 0, the counter advances by one.
- R7: A write to address 0 leaves the prescaler (count bits 1:0) running without a break.
- R8: A write to the counter while it is in the four-clock zero window cancels both the reload and the interrupt, and the written value stays.
- R9: `frame_ce` is a one-clock pulse, one clock after each falling edge of count bit 12. This includes a falling edge caused by a divider write.
- R10: The address map is 0 divider, 1 counter, 2 modulo, 3 control. Control reads back its 3 written bits, with the upper bits reading 0, and the modulo register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 2 | Register select |
| cpu_wr | input | 1 | Write strobe, one clock per write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| timer_irq | output | 1 | One-clock interrupt request on reload |
| frame_ce | output | 1 | One-clock audio frame sequencer enable |

## Verification
A falling edge of the gated bit reaches the counter one clock later, and the read port shows it one clock after that. The zero window lasts four clocks, and the reload and interrupt land on the fifth clock after the wrapping increment. `frame_ce` rises one clock after bit 12 falls. The bench runs a reference model of these latencies at each rising edge and compares every output at the following falling edge. Hand-computed checks for enable clearing, divider writes and window cancels are timed with these same offsets.

// File: rtl/divtim_pkg.sv
package divtim_pkg;
  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_CNT = 2'd1,
    REG_MOD = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  localparam int unsigned TAP_OPTS = 4;

  // count bit clocking the counter for each select code
  function automatic int unsigned tap_index(input int unsigned sel);
    case (sel)
      0: tap_index = 9;
      1: tap_index = 3;
      2: tap_index = 5;
      default: tap_index = 7;
    endcase
  endfunction
endpackage

// File: rtl/divtim_divider.sv
module divtim_divider #(
  parameter int unsigned PRE_W = 2,
  parameter int unsigned DIV_W = 14,
  localparam int unsigned CNT_W = PRE_W + DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (clr)
        div_q <= '0;
      else if (&pre_q)
        div_q <= div_q + DIV_W'(1);
    end
  end

  assign count = {div_q, pre_q};
endmodule

// File: rtl/divtim_tapsel.sv
module divtim_tapsel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       sel,
  input  logic             en,
  output logic             tap
);
  import divtim_pkg::*;

  logic [TAP_OPTS-1:0] cand;

  for (genvar i = 0; i < TAP_OPTS; i++) begin : g_tap
    assign cand[i] = count[tap_index(i)];
  end

  assign tap = en & cand[sel];
endmodule

// File: rtl/divtim_fall.sv
module divtim_fall (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign fall = prev_q & ~level;
endmodule

// File: rtl/divtim_counter.sv
module divtim_counter #(
  parameter int unsigned DW  = 8,
  parameter int unsigned WIN = 4,
  localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] mod_val,
  output logic [DW-1:0] cnt_q,
  output logic          busy_q,
  output logic          irq_q
);
  logic [WW-1:0] win_q;
  logic [DW:0]   sum;

  assign sum = {1'b0, cnt_q} + (DW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      win_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load_en) begin
        cnt_q  <= load_val;
        busy_q <= 1'b0;
      end else if (busy_q && win_q == '0) begin
        cnt_q  <= mod_val;
        busy_q <= 1'b0;
        irq_q  <= 1'b1;
      end else begin
        if (busy_q) win_q <= win_q - WW'(1);
        if (inc) begin
          cnt_q <= sum[DW-1:0];
          if (sum[DW]) begin
            busy_q <= 1'b1;
            win_q  <= WW'(WIN - 1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/divtim_top.sv
module divtim_top #(
  parameter int unsigned PRE_W     = 2,
  parameter int unsigned DIV_W     = 14,
  parameter int unsigned DW        = 8,
  parameter int unsigned CTL_W     = 3,
  parameter int unsigned FRAME_BIT = 12,
  parameter int unsigned WIN       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          timer_irq,
  output logic          frame_ce
);
  import divtim_pkg::*;

  localparam int unsigned CNT_W = PRE_W + DIV_W;

  logic [CNT_W-1:0] count_w;
  logic [DW-1:0]    cnt_w;
  logic [DW-1:0]    tma_q;
  logic [CTL_W-1:0] ctl_q;
  logic             busy_w;
  logic             tap_w;
  logic             inc_w;
  logic             frame_fall;
  logic             wr_div, wr_cnt, wr_mod, wr_ctl;
  logic [DW-1:0]    rd_mux;

  assign wr_div = cpu_wr && (cpu_addr == REG_DIV);
  assign wr_cnt = cpu_wr && (cpu_addr == REG_CNT);
  assign wr_mod = cpu_wr && (cpu_addr == REG_MOD);
  assign wr_ctl = cpu_wr && (cpu_addr == REG_CTL);

  divtim_divider #(.PRE_W(PRE_W), .DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .clr(wr_div), .count(count_w)
  );

  divtim_tapsel #(.CNT_W(CNT_W)) tap_i (
    .count(count_w), .sel(ctl_q[1:0]), .en(ctl_q[2]), .tap(tap_w)
  );

  divtim_fall tap_edge_i (
    .clk(clk), .rst(rst), .level(tap_w), .fall(inc_w)
  );

  divtim_fall frame_edge_i (
    .clk(clk), .rst(rst), .level(count_w[FRAME_BIT]), .fall(frame_fall)
  );

  divtim_counter #(.DW(DW), .WIN(WIN)) cnt_i (
    .clk(clk), .rst(rst), .inc(inc_w), .load_en(wr_cnt),
    .load_val(cpu_wdata[DW-1:0]), .mod_val(tma_q),
    .cnt_q(cnt_w), .busy_q(busy_w), .irq_q(timer_irq)
  );

  always_comb begin
    case (cpu_addr)
      REG_DIV: rd_mux = count_w[CNT_W-1 -: DW];
      REG_CNT: rd_mux = cnt_w;
      REG_MOD: rd_mux = tma_q;
      default: rd_mux = {{(DW-CTL_W){1'b0}}, ctl_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tma_q     <= '0;
      ctl_q     <= '0;
      cpu_rdata <= '0;
      frame_ce  <= 1'b0;
    end else begin
      if (wr_mod) tma_q <= cpu_wdata[DW-1:0];
      if (wr_ctl) ctl_q <= cpu_wdata[CTL_W-1:0];
      cpu_rdata <= rd_mux;
      frame_ce  <= frame_fall;
    end
  end
endmodule

// File: rtl/divtim_chk.sv
module divtim_chk #(
  parameter int unsigned PRE_W = 2,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cpu_addr,
  input logic             cpu_wr,
  input logic             timer_irq,
  input logic             frame_ce,
  input logic [CNT_W-1:0] count,
  input logic [DW-1:0]    cnt,
  input logic [DW-1:0]    tma,
  input logic             busy
);
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    timer_irq |=> !timer_irq);

  assert_reload_value_R5: assert property (@(posedge clk) disable iff (rst)
    timer_irq |-> cnt == $past(tma));

  assert_frame_single_R9: assert property (@(posedge clk) disable iff (rst)
    frame_ce |=> !frame_ce);

  assert_div_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 2'd0) |=> count[CNT_W-1:PRE_W] == '0);

  assert_prescale_runs_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (count[PRE_W-1:0] - $past(count[PRE_W-1:0])) == PRE_W'(1));

  assert_cancel_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && cpu_wr && cpu_addr == 2'd1) |=> !timer_irq);
endmodule

bind divtim_top divtim_chk #(.PRE_W(PRE_W), .CNT_W(PRE_W + DIV_W), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .timer_irq(timer_irq), .frame_ce(frame_ce), .count(count_w),
  .cnt(cnt_w), .tma(tma_q), .busy(busy_w)
);

// File: tb/divtim_top_tb_top.sv
`timescale 1ns/1ps
module divtim_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       irq, frame;

  int errors = 0;
  int checks = 0;
  string phase = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divtim_top dut_i (
    .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wr(wr), .cpu_wdata(wd),
    .cpu_rdata(rdata), .timer_irq(irq), .frame_ce(frame)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt16;
  logic [7:0]  m_tima, m_tma, m_rd;
  logic [2:0]  m_ctl;
  logic        m_tapq, m_fprev, m_busy, m_irq, m_frame;
  int          m_win;

  function automatic int tap_of(input logic [1:0] s);
    case (s)
      2'd0: return 9;
      2'd1: return 3;
      2'd2: return 5;
      default: return 7;
    endcase
  endfunction

  always @(posedge clk) begin
    logic tap_now, inc, fr;
    logic [8:0] s;
    if (rst) begin
      m_cnt16 = 0; m_tima = 0; m_tma = 0; m_rd = 0; m_ctl = 0;
      m_tapq = 0; m_fprev = 0; m_busy = 0; m_irq = 0; m_frame = 0; m_win = 0;
    end else begin
      tap_now = m_ctl[2] & m_cnt16[tap_of(m_ctl[1:0])];
      inc = m_tapq & ~tap_now;
      m_tapq = tap_now;
      fr = m_fprev & ~m_cnt16[12];
      m_fprev = m_cnt16[12];
      case (addr)
        2'd0: m_rd = m_cnt16[15:8];
        2'd1: m_rd = m_tima;
        2'd2: m_rd = m_tma;
        default: m_rd = {5'd0, m_ctl};
      endcase
      m_irq = 0;
      if (wr && addr == 2'd1) begin
        m_tima = wd; m_busy = 0;
      end else if (m_busy && m_win == 0) begin
        m_tima = m_tma; m_busy = 0; m_irq = 1;
      end else begin
        if (m_busy) m_win = m_win - 1;
        if (inc) begin
          s = {1'b0, m_tima} + 9'd1;
          m_tima = s[7:0];
          if (s[8]) begin m_busy = 1; m_win = 3; end
        end
      end
      m_frame = fr;
      if (wr && addr == 2'd2) m_tma = wd;
      if (wr && addr == 2'd3) m_ctl = wd[2:0];
      if (wr && addr == 2'd0) m_cnt16 = {14'd0, m_cnt16[1:0] + 2'd1};
      else m_cnt16 = m_cnt16 + 16'd1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({phase, " rdata"}, rdata, m_rd);
      check({phase, " irq"}, irq, m_irq);
      check({phase, " frame_ce"}, frame, m_frame);
    end
  end

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d, input logic [1:0] view);
    @(negedge clk);
    addr = a; wr = 1'b1; wd = d;
    @(negedge clk);
    wr = 1'b0; addr = view;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] c0;
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state on every address
    phase = "R1";
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      @(negedge clk);
      if (a != 0) check("R1 reg reset", rdata, 0);
    end
    check("R1 irq reset", irq, 0);
    check("R1 frame reset", frame, 0);

    // R2: free running divider observed through address 0
    phase = "R2";
    addr = 2'd0;
    idle(3000);

    // R10: register map read back
    phase = "R10";
    write_reg(2'd2, 8'h5A, 2'd2);
    @(negedge clk); check("R10 modulo readback", rdata, 8'h5A);
    write_reg(2'd3, 8'hFB, 2'd3);
    @(negedge clk); check("R10 control readback", rdata, 8'h03);

    // R3/R5: sweep every tap with the counter preset near wrap
    for (int s = 0; s < 4; s++) begin
      phase = "R3/R5";
      write_reg(2'd3, 8'd0, 2'd1);
      write_reg(2'd2, 8'(8'h30 + s * 8'h11), 2'd1);
      write_reg(2'd1, 8'hFD, 2'd1);
      write_reg(2'd3, 8'(4 | s), 2'd1);
      seen = 0;
      for (int k = 0; k < 5000; k++) begin
        @(negedge clk);
        if (irq) begin
          seen++;
          @(negedge clk);
          check("R5 reload to modulo", rdata, 8'h30 + s * 8'h11);
        end
      end
      check("R5 interrupt seen", seen > 0, 1);
    end

    // R4: clear enable while the selected bit is high
    phase = "R4";
    write_reg(2'd3, 8'h05, 2'd1);
    write_reg(2'd1, 8'h10, 2'd1);
    while (!(m_cnt16[3] && m_cnt16[2:0] == 3'd1)) @(negedge clk);
    c0 = rdata;
    write_reg(2'd3, 8'h01, 2'd1);
    idle(3);
    check("R4 enable clear increments", rdata, c0 + 8'd1);

    // R6/R7: divider write drops the selected bit
    phase = "R6/R7";
    write_reg(2'd3, 8'h06, 2'd1);
    idle(2);
    while (!(m_cnt16[5] && m_cnt16[4:0] == 5'd1)) @(negedge clk);
    c0 = rdata;
    write_reg(2'd0, 8'h00, 2'd1);
    idle(3);
    check("R6 divider write increments", rdata, c0 + 8'd1);
    for (int k = 0; k < 5; k++) begin
      write_reg(2'd0, 8'hFF, 2'd1);
      idle(k * 3 + 20);
    end

    // R8: write to the counter inside the zero window
    phase = "R8";
    write_reg(2'd3, 8'h05, 2'd1);
    write_reg(2'd1, 8'hFF, 2'd1);
    while (!m_busy) @(negedge clk);
    write_reg(2'd1, 8'h42, 2'd1);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    check("R8 no interrupt after cancel", seen, 0);
    check("R8 written value kept", rdata, 8'h42);

    // R9: frame enable from bit 12, also after a divider write
    phase = "R9";
    addr = 2'd0;
    idle(17000);
    while (!m_cnt16[12]) @(negedge clk);
    write_reg(2'd0, 8'h00, 2'd0);
    seen = 0;
    for (int k = 0; k < 3; k++) begin
      if (frame) seen++;
      @(negedge clk);
    end
    check("R9 pulse after divider write", seen, 1);
    idle(100);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule